// File: doc/BRIEF.md
# I2C Master Command and Receive Queue Front End

This block sits between a register port and a byte-level I2C bus engine. Software writes command words into one data/command register. Each word either carries a byte to send or asks for one byte to be read. Every word goes into a transmit command queue. A sequencer takes words from the head of that queue and hands them one at a time to the byte engine. It adds START, repeated START and STOP requests as the transfer direction and the queue contents call for. Bytes that come back from read requests go into a receive queue, and software drains that queue by reading the same data/command register.

Software programs a target address, a control register that holds the stop-hold and repeated-start options, and an enable register. A separate enable-status register shows when the controller has really started or stopped. When stop-hold is set, an empty command queue leaves the bus open, so a transaction can span more than one software refill. Clearing stop-hold while the queue is empty lets the STOP go out.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: A write to the data register (address 2) with bit 8 clear queues bits 7:0 as a byte to send, and the engine receives it with `eng_rd`=0. With bit 8 set, the write queues a read request, the engine receives it with `eng_rd`=1, and the byte the engine returns goes into the receive queue.
- R2: A read of the data register returns the oldest received byte in bits 7:0 and removes it. When the receive queue is empty, the read returns 0 and `rx_unf` is high in that cycle.
- R3: Each queue holds 16 entries. A data-register write that arrives while the command queue is full is dropped, and `tx_ovf` is high in that cycle.
- R4: The status register (address 3) reads as follows. Bit 0 is high while the controller is busy or has commands queued. Bit 1 means the command queue is not full and bit 2 means it is empty. Bit 3 means the receive queue is not empty and bit 4 means it is full. Bit 5 means the master is in a transaction. Bit 6 is 0.
- R5: The first command after idle goes out with `eng_op`=1 (START), carrying the target address as it was latched at that moment. Later commands in the same direction go out with `eng_op`=0 (plain byte).
- R6: When the direction changes between consecutive commands, the next command goes out with `eng_op`=1 if control bit 5 is set. If control bit 5 is clear, a STOP (`eng_op`=2) is issued first and the next command then starts again with START.
- R7: When the command queue empties and control bit 7 (stop-hold) is clear, a STOP follows. When stop-hold is set, no request is made and the bus stays in the transaction until more commands arrive, which continue with `eng_op`=0, or until stop-hold is cleared, which issues a STOP.
- R8: Enable (address 4, bit 0) gates the sequencer, so no engine request is made while it is 0. Enable-status (address 5, bit 0) follows enable with a lag.
- R9: Clearing enable never cuts a request short. The engine request in flight completes, a STOP follows, and enable-status falls only after the controller has gone idle.
- R10: A write to the target register (address 1) takes effect only while the command queue is empty and the master is idle. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue when it addresses the data register) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 9 | Write data; bit 8 is the read flag for data-register writes |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| tx_ovf | output | 1 | A data-register write was dropped because the command queue was full |
| rx_unf | output | 1 | A data-register read found the receive queue empty |
| eng_req | output | 1 | Request to the byte engine, held until `eng_done` |
| eng_op | output | 2 | 0 plain byte, 1 START then byte, 2 STOP only |
| eng_rd | output | 1 | The requested byte is a read |
| eng_addr | output | 7 | Target address latched at the first START |
| eng_byte | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine finished the current request |
| eng_rxd | input | 8 | Byte received by the engine, valid with `eng_done` |

## Verification
A table of eight mixed command words is queued while the controller is disabled and then released in one burst with repeated START enabled. Because the run alternates same-direction and direction-change neighbours, it separates plain-byte continuation from repeated START, and write payloads from read requests. The same write-then-read pair is then replayed with repeated START disabled, which must produce a STOP and a fresh START between the two commands. Stop-hold runs check that an empty queue holds the bus and that a later refill continues without a START. A 17-word fill and a 16-read fill, followed by an extra read, exercise the full and empty edges of both queues. A disable issued while a byte is in flight confirms that the byte completes and that enable-status lags.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

   // register map of the front end
   typedef enum logic [2:0] {
      RA_CTRL   = 3'd0,
      RA_TARGET = 3'd1,
      RA_DATA   = 3'd2,
      RA_STATUS = 3'd3,
      RA_ENABLE = 3'd4,
      RA_ENSTAT = 3'd5
   } reg_addr_e;

   // request kinds handed to the byte engine
   typedef enum logic [1:0] {
      OP_BYTE  = 2'd0,
      OP_START = 2'd1,
      OP_STOP  = 2'd2
   } eng_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_XFER,
      SQ_SEAM,
      SQ_STOP
   } seq_state_e;

   localparam int unsigned CTRL_RESTART_BIT = 5;
   localparam int unsigned CTRL_HOLD_BIT    = 7;

endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("i2cfe_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_width_bad
         $error("i2cfe_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;
   logic             push_ok, pop_ok;

   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   // pointer wrap: free-running for a power of two, compare otherwise
   generate
      if (DEPTH == (1 << AW)) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   // R3: a push into a full queue leaves the occupancy unchanged
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/i2cfe_seq.sv
module i2cfe_seq
   import i2cfe_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          stop_hold,
   input  logic          restart_en,
   input  logic          cmd_empty,
   input  logic [DW:0]   cmd_head,
   output logic          cmd_pop,
   output logic          latch_addr,
   output logic          busy,
   output logic          rx_push,
   output logic [DW-1:0] rx_byte,
   output logic          eng_req,
   output eng_op_e       eng_op,
   output logic          eng_rd,
   output logic [DW-1:0] eng_byte,
   input  logic          eng_done,
   input  logic [DW-1:0] eng_rxd
);

   seq_state_e    state_q, state_d;
   eng_op_e       op_q, op_d;
   logic          rd_q, rd_d, dir_q, dir_d;
   logic [DW-1:0] byte_q, byte_d;
   logic          head_rd, dir_flip;

   assign head_rd  = cmd_head[DW];
   assign dir_flip = (head_rd != dir_q);

   always_comb begin
      state_d    = state_q;
      op_d       = op_q;
      rd_d       = rd_q;
      dir_d      = dir_q;
      byte_d     = byte_q;
      cmd_pop    = 1'b0;
      latch_addr = 1'b0;
      case (state_q)
         SQ_IDLE: begin
            if (enable && !cmd_empty) begin
               cmd_pop    = 1'b1;
               latch_addr = 1'b1;
               op_d       = OP_START;
               rd_d       = head_rd;
               dir_d      = head_rd;
               byte_d     = cmd_head[DW-1:0];
               state_d    = SQ_XFER;
            end
         end
         SQ_XFER: begin
            if (eng_done) state_d = SQ_SEAM;
         end
         SQ_SEAM: begin
            if (enable && !cmd_empty) begin
               if (dir_flip && !restart_en) begin
                  op_d    = OP_STOP;
                  rd_d    = 1'b0;
                  state_d = SQ_STOP;
               end else begin
                  cmd_pop = 1'b1;
                  op_d    = dir_flip ? OP_START : OP_BYTE;
                  rd_d    = head_rd;
                  dir_d   = head_rd;
                  byte_d  = cmd_head[DW-1:0];
                  state_d = SQ_XFER;
               end
            end else if (!(enable && stop_hold)) begin
               op_d    = OP_STOP;
               rd_d    = 1'b0;
               state_d = SQ_STOP;
            end
         end
         SQ_STOP: begin
            if (eng_done) state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         op_q    <= OP_BYTE;
         rd_q    <= 1'b0;
         dir_q   <= 1'b0;
         byte_q  <= '0;
      end else begin
         state_q <= state_d;
         op_q    <= op_d;
         rd_q    <= rd_d;
         dir_q   <= dir_d;
         byte_q  <= byte_d;
      end
   end

   assign eng_req  = (state_q == SQ_XFER) || (state_q == SQ_STOP);
   assign eng_op   = op_q;
   assign eng_rd   = rd_q;
   assign eng_byte = byte_q;
   assign busy     = (state_q != SQ_IDLE);
   assign rx_push  = (state_q == SQ_XFER) && eng_done && rd_q;
   assign rx_byte  = eng_rxd;

   // R9: a request is never withdrawn or altered before the engine finishes
   a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte) && $stable(eng_rd)));

   // R7: holding with an empty queue and stop-hold set makes no request
   a_r7_hold_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_SEAM && enable && stop_hold && cmd_empty) |=> !eng_req);

   // R5: leaving idle always begins with a START
   a_r5_first_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eng_req) && $past(state_q == SQ_IDLE)) |-> (eng_op == OP_START));

endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
   import i2cfe_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 7,
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W:0]   reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              tx_ovf,
   output logic              rx_unf,
   output logic              eng_req,
   output logic [1:0]        eng_op,
   output logic              eng_rd,
   output logic [ADDR_W-1:0] eng_addr,
   output logic [DATA_W-1:0] eng_byte,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rxd
);

   localparam int CMD_W = DATA_W + 1;

   generate
      if (DATA_W < 8) begin : g_dw_bad
         $error("i2c_cmd_frontend: DATA_W must be at least 8");
      end
      if (ADDR_W > DATA_W) begin : g_aw_bad
         $error("i2c_cmd_frontend: ADDR_W must not exceed DATA_W");
      end
   endgenerate

   logic              ctrl_hold_q, ctrl_restart_q, en_q, en_stat_q;
   logic [ADDR_W-1:0] tgt_q, addr_q;

   logic              tx_push, tx_pop, tx_empty, tx_full;
   logic [CMD_W-1:0]  tx_head;
   logic              rx_push, rx_pop, rx_empty, rx_full;
   logic [DATA_W-1:0] rx_head, rx_in;
   logic              busy, latch_addr;
   eng_op_e           op_int;

   logic wr_ctrl, wr_tgt, wr_data, wr_en, rd_data;
   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_tgt  = reg_wr && (reg_addr == RA_TARGET);
   assign wr_data = reg_wr && (reg_addr == RA_DATA);
   assign wr_en   = reg_wr && (reg_addr == RA_ENABLE);
   assign rd_data = reg_rd && (reg_addr == RA_DATA);

   assign tx_push = wr_data;
   assign tx_ovf  = wr_data && tx_full;
   assign rx_pop  = rd_data;
   assign rx_unf  = rd_data && rx_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_hold_q    <= 1'b0;
         ctrl_restart_q <= 1'b0;
         en_q           <= 1'b0;
         en_stat_q      <= 1'b0;
         tgt_q          <= '0;
         addr_q         <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_hold_q    <= reg_wdata[CTRL_HOLD_BIT];
            ctrl_restart_q <= reg_wdata[CTRL_RESTART_BIT];
         end
         if (wr_en) en_q <= reg_wdata[0];
         // status follows the request, but stays up until the sequencer is idle
         en_stat_q <= en_q || busy;
         if (wr_tgt && tx_empty && !busy) tgt_q <= reg_wdata[ADDR_W-1:0];
         if (latch_addr) addr_q <= tgt_q;
      end
   end

   i2cfe_fifo #(.DEPTH(TX_DEPTH), .WIDTH(CMD_W)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(reg_wdata),
      .pop(tx_pop), .rdata(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   i2cfe_fifo #(.DEPTH(RX_DEPTH), .WIDTH(DATA_W)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .wdata(rx_in),
      .pop(rx_pop), .rdata(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   i2cfe_seq #(.DW(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .enable(en_q), .stop_hold(ctrl_hold_q), .restart_en(ctrl_restart_q),
      .cmd_empty(tx_empty), .cmd_head(tx_head), .cmd_pop(tx_pop),
      .latch_addr(latch_addr), .busy(busy),
      .rx_push(rx_push), .rx_byte(rx_in),
      .eng_req(eng_req), .eng_op(op_int), .eng_rd(eng_rd), .eng_byte(eng_byte),
      .eng_done(eng_done), .eng_rxd(eng_rxd)
   );

   assign eng_op   = op_int;
   assign eng_addr = addr_q;

   always_comb begin
      case (reg_addr)
         RA_CTRL:   reg_rdata = DATA_W'({ctrl_hold_q, 1'b0, ctrl_restart_q, 5'b0});
         RA_TARGET: reg_rdata = DATA_W'(tgt_q);
         RA_DATA:   reg_rdata = rx_empty ? '0 : rx_head;
         RA_STATUS: reg_rdata = DATA_W'({1'b0, busy, rx_full, !rx_empty,
                                         tx_empty, !tx_full, busy || !tx_empty});
         RA_ENABLE: reg_rdata = DATA_W'(en_q);
         RA_ENSTAT: reg_rdata = DATA_W'(en_stat_q);
         default:   reg_rdata = '0;
      endcase
   end

   // R10: the target only moves when the queue was empty and the master idle
   a_r10_target_guard: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tgt_q) |-> $past(tx_empty && !busy));

   // R2: an empty-queue read returns zero
   a_r2_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rx_unf |-> (reg_rdata == '0));

   // R9: enable-status cannot drop while a request is outstanding
   a_r9_enstat_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> en_stat_q);

endmodule

// File: tb/i2c_cmd_frontend_tb.sv
`timescale 1ns/1ps
module i2c_cmd_frontend_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [8:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tx_ovf, rx_unf, eng_req, eng_rd;
   logic [1:0] eng_op;
   logic [6:0] eng_addr;
   logic [7:0] eng_byte;
   logic       eng_done;
   logic [7:0] eng_rxd;

   always #5 clk = ~clk;

   i2c_cmd_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_ovf(tx_ovf), .rx_unf(rx_unf), .eng_req(eng_req), .eng_op(eng_op),
      .eng_rd(eng_rd), .eng_addr(eng_addr), .eng_byte(eng_byte),
      .eng_done(eng_done), .eng_rxd(eng_rxd)
   );

   // byte engine model: each request completes on its third cycle
   int         log_n;
   logic [1:0] lop   [128];
   logic       lrd   [128];
   logic [7:0] lbyte [128];
   logic [6:0] laddr [128];
   int         ecnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         ecnt     <= 0;
         eng_done <= 1'b0;
         eng_rxd  <= '0;
         log_n    <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_req && !eng_done) begin
            if (ecnt == 2) begin
               eng_done <= 1'b1;
               eng_rxd  <= 8'(8'h50 + log_n);
               if (log_n < 128) begin
                  lop[log_n]   <= eng_op;
                  lrd[log_n]   <= eng_rd;
                  lbyte[log_n] <= eng_byte;
                  laddr[log_n] <= eng_addr;
               end
               log_n <= log_n + 1;
               ecnt  <= 0;
            end else begin
               ecnt <= ecnt + 1;
            end
         end
      end
   end

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [8:0] d, output logic ovf);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      #1 ovf = tx_ovf;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic unf);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata; unf = rx_unf;
      @(posedge clk);
      #1 reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      logic u;
      for (int i = 0; i < 3000; i++) begin
         rd(3'd3, s, u);
         if (s[0] == 1'b0) break;
      end
   endtask

   localparam logic [8:0] VEC [8] = '{9'h0A5, 9'h03C, 9'h100, 9'h100,
                                      9'h0FF, 9'h100, 9'h011, 9'h100};

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      logic o, u;
      int base, nrd, prev, expop;
      int rdidx [16];

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      rd(3'd3, d, u); chk("R4 reset status", d, 8'h06);
      rd(3'd5, d, u); chk("R8 reset enstat", d, 0);
      rd(3'd0, d, u); chk("R7 reset ctrl", d, 0);
      chk("R8 reset eng_req", eng_req, 0);

      // vector table, repeated START on, queued while disabled
      wr(3'd0, 9'h020, o);
      wr(3'd1, 9'h02A, o);
      base = log_n;
      foreach (VEC[i]) wr(3'd2, VEC[i], o);
      repeat (20) @(negedge clk);
      chk("R8 no request while disabled", log_n - base, 0);
      rd(3'd3, d, u); chk("R4 queued status", d, 8'h03);
      wr(3'd4, 9'h001, o);
      repeat (3) @(negedge clk);
      rd(3'd5, d, u); chk("R8 enstat follows", d, 1);
      wait_idle();
      chk("R7 vector count plus stop", log_n - base, 9);
      prev = 0; nrd = 0;
      foreach (VEC[i]) begin
         expop = (i == 0 || int'(VEC[i][8]) != prev) ? 1 : 0;
         prev  = int'(VEC[i][8]);
         chk("R5 R6 op", lop[base+i], expop);
         chk("R1 read flag", lrd[base+i], VEC[i][8]);
         chk("R5 address", laddr[base+i], 7'h2A);
         if (!VEC[i][8]) chk("R1 byte", lbyte[base+i], VEC[i][7:0]);
         else begin rdidx[nrd] = base + i; nrd++; end
      end
      chk("R7 final stop", lop[base+8], 2);
      for (int i = 0; i < nrd; i++) begin
         rd(3'd2, d, u);
         chk("R2 rx order", d, 8'(8'h50 + rdidx[i]));
         chk("R2 no underflow", u, 0);
      end
      rd(3'd3, d, u); chk("R4 rx drained", d[3], 0);

      // disable while a byte is in flight
      wr(3'd0, 9'h000, o);
      base = log_n;
      wr(3'd2, 9'h077, o);
      wr(3'd4, 9'h000, o);
      rd(3'd5, d, u); chk("R9 enstat held while busy", d, 1);
      repeat (30) @(negedge clk);
      chk("R9 byte completed then stop", log_n - base, 2);
      chk("R9 byte op", lop[base], 1);
      chk("R9 byte value", lbyte[base], 8'h77);
      chk("R9 stop op", lop[base+1], 2);
      rd(3'd5, d, u); chk("R9 enstat low when idle", d, 0);

      // stop-hold
      wr(3'd4, 9'h001, o);
      wr(3'd0, 9'h080, o);
      base = log_n;
      wr(3'd2, 9'h0C3, o);
      repeat (30) @(negedge clk);
      chk("R7 held no stop", log_n - base, 1);
      chk("R7 held eng_req low", eng_req, 0);
      rd(3'd3, d, u); chk("R4 held status", d, 8'h27);
      wr(3'd1, 9'h055, o);
      rd(3'd1, d, u); chk("R10 target ignored while busy", d, 8'h2A);
      wr(3'd2, 9'h0D4, o);
      repeat (20) @(negedge clk);
      chk("R7 refill continues", log_n - base, 2);
      chk("R7 refill plain byte", lop[base+1], 0);
      chk("R7 refill value", lbyte[base+1], 8'hD4);
      wr(3'd0, 9'h000, o);
      wait_idle();
      repeat (10) @(negedge clk);
      chk("R7 stop after clear", lop[base+2], 2);
      wr(3'd1, 9'h055, o);
      rd(3'd1, d, u); chk("R10 target accepted when idle", d, 8'h55);

      // direction change with repeated START disabled
      wr(3'd4, 9'h000, o);
      repeat (5) @(negedge clk);
      base = log_n;
      wr(3'd2, 9'h0E1, o);
      wr(3'd2, 9'h100, o);
      wr(3'd4, 9'h001, o);
      wait_idle();
      chk("R6 count", log_n - base, 4);
      chk("R6 first start", lop[base], 1);
      chk("R6 stop before turn", lop[base+1], 2);
      chk("R6 new start", lop[base+2], 1);
      chk("R6 read flag", lrd[base+2], 1);
      chk("R6 trailing stop", lop[base+3], 2);
      chk("R5 new address", laddr[base+2], 7'h55);
      rd(3'd2, d, u); chk("R1 read byte returned", d, 8'(8'h50 + base + 2));

      // command queue overflow
      wr(3'd4, 9'h000, o);
      repeat (5) @(negedge clk);
      base = log_n;
      for (int i = 0; i < 16; i++) begin
         wr(3'd2, 9'(i), o);
         chk("R3 no overflow below full", o, 0);
      end
      rd(3'd3, d, u); chk("R4 tx full status", d, 8'h01);
      wr(3'd2, 9'h0AA, o);
      chk("R3 overflow flagged", o, 1);
      wr(3'd4, 9'h001, o);
      wait_idle();
      chk("R3 only 16 sent", log_n - base, 17);
      chk("R3 last kept byte", lbyte[base+15], 8'h0F);

      // receive queue full, then underflow
      wr(3'd4, 9'h000, o);
      repeat (5) @(negedge clk);
      base = log_n;
      for (int i = 0; i < 16; i++) wr(3'd2, 9'h100, o);
      wr(3'd4, 9'h001, o);
      wait_idle();
      rd(3'd3, d, u); chk("R4 rx full status", d, 8'h1E);
      for (int i = 0; i < 16; i++) begin
         rd(3'd2, d, u);
         chk("R2 rx fill order", d, 8'(8'h50 + base + i));
      end
      rd(3'd2, d, u);
      chk("R2 empty read zero", d, 0);
      chk("R2 underflow flagged", u, 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule